// File: doc/BRIEF.md
# Serial NOR Programmed-I/O Byte Reader

This block fetches single bytes from a serial NOR flash under software control. Software first sets up a small register file with four things: the read opcode, a fast-read enable, a lane-width selector and a start address split over four byte registers. It then writes a start code to the command register. The engine selects the flash and shifts out the opcode and a 24-bit address. It adds dummy clocks when the chosen mode needs them, then captures one data byte on one, two or four lanes.

When the byte is complete, the engine deselects the flash and places the byte in a read-data register. It advances the stored address by one and clears the start code in the command register. Software polls the command register for that clear and then reads the byte. Issuing the command again returns the next byte of the flash.

The serial clock runs at half the system clock. Outgoing bits change while the serial clock is low, and incoming bits are sampled on its rising edge.

Top module: `nor_pio_reader`

## Requirements
- R1: After reset every register reads 0x00, the chip select is high, the serial clock is low and no lane is driven.
- R2: Writing 0x81 to offset 0x00 while idle starts one read. The flash is selected and the opcode held at offset 0x2C is sent MSB first on lane 0. Offset 0x00 reads 0x81 until the byte is complete and 0x00 afterwards. Any other value written there starts nothing.
- R3: The low 24 address bits are sent MSB first after the opcode. The address bytes sit at 0x10 (bits 7:0), 0x14 (15:8), 0x18 (23:16) and 0xC8 (31:24). They go out on lane 0 only, unless bit 1 of offset 0xCC is set (two lanes, upper bit on lane 1) or bit 3 is set (four lanes, lanes 3..0). Bit 3 wins when both are set.
- R4: Eight dummy clocks follow the address when bit 0 of offset 0x60 is set, or when bit 0 or bit 2 of offset 0xCC is set. Otherwise data follows the address directly.
- R5: Data width follows offset 0xCC. With bit 2 set, 4 bits per clock arrive on lanes 3..0. Otherwise, with bit 0 set, 2 bits per clock arrive on lanes 1..0, upper bit on lane 1. Otherwise 1 bit per clock arrives on lane 1. Data is MSB first, and no lane is driven during dummy or data clocks.
- R6: When the last data clock ends, the chip select rises and the byte appears at offset 0x0C in that same cycle.
- R7: After each byte the 32-bit address in the four address registers increases by one. The carry runs across all four bytes, and 0xFFFFFFFF wraps to 0.
- R8: While a read is in progress, writes to any offset have no effect, including a second start code.
- R9: The serial clock stays low while the chip select is high. A transfer holds exactly 8 + 24/address-lanes + dummy + 8/data-lanes serial clock pulses.
- R10: The opcode register keeps 8 bits, offset 0x60 keeps only bit 0 and offset 0xCC keeps only bits 3..0. Unmapped offsets read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock to flash |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_io_out | output | 4 | Outgoing lane values |
| spi_io_oe | output | 4 | Per-lane output enable |
| spi_io_in | input | 4 | Incoming lane values |

## Verification
The assertions assume that software issues no write to the register file while a read is running, apart from deliberate ones that the engine must discard. They also assume the flash drives the lanes only after the dummy clocks. The stimulus configures the mode and address only while the engine is idle. It confines its illegal traffic to one marked window in which it writes the opcode, an address byte and a second start code during a live transfer. The flash model changes its lane outputs only on the falling serial edge, so every sample the engine takes sees settled data.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

    localparam int unsigned REG_AW         = 8;
    localparam int unsigned REG_DW         = 8;
    localparam int unsigned NUM_IO         = 4;
    localparam int unsigned NUM_ADDR_BYTES = 4;

    localparam logic [REG_AW-1:0] OFS_CMD   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_RDATA = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_OPC   = 8'h2C;
    localparam logic [REG_AW-1:0] OFS_CFG   = 8'h60;
    localparam logic [REG_AW-1:0] OFS_LANE  = 8'hCC;

    localparam logic [REG_DW-1:0] CMD_PIO_RD = 8'h81;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        LW_X1 = 2'd0,
        LW_X2 = 2'd1,
        LW_X4 = 2'd2
    } lane_w_e;

    typedef struct packed {
        lane_w_e addr_w;
        lane_w_e data_w;
        logic    dummy;
    } xfer_mode_t;

    function automatic logic [REG_AW-1:0] addr_byte_ofs(input int unsigned idx);
        case (idx)
            0:       return 8'h10;
            1:       return 8'h14;
            2:       return 8'h18;
            default: return 8'hC8;
        endcase
    endfunction

    function automatic int unsigned lane_bits(input lane_w_e w);
        case (w)
            LW_X4:   return 4;
            LW_X2:   return 2;
            default: return 1;
        endcase
    endfunction

    // Quad settings take priority over dual settings for both phases.
    function automatic xfer_mode_t mode_of(input logic fast_en, input logic [3:0] lane_cfg);
        xfer_mode_t m;
        m.addr_w = lane_cfg[3] ? LW_X4 : (lane_cfg[1] ? LW_X2 : LW_X1);
        m.data_w = lane_cfg[2] ? LW_X4 : (lane_cfg[0] ? LW_X2 : LW_X1);
        m.dummy  = fast_en | lane_cfg[0] | lane_cfg[2];
        return m;
    endfunction

endpackage

// File: rtl/nor_rd_regs.sv
module nor_rd_regs
    import nor_rd_pkg::*;
#(
    parameter int unsigned ABITS = 24,
    parameter int unsigned NAB   = NUM_ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    input  logic              busy,
    input  logic              done,
    input  logic [7:0]        rx_byte,
    output logic              start,
    output logic [7:0]        opcode,
    output logic              fast_en,
    output logic [3:0]        lane_cfg,
    output logic [ABITS-1:0]  flash_addr
);

    localparam int unsigned FULL_AW = 8 * NAB;

    logic [FULL_AW-1:0] addr_q;
    logic [7:0]         opc_q;
    logic [7:0]         rdata_q;
    logic               fast_q;
    logic [3:0]         lane_q;
    logic               wr_ok;
    logic [NAB-1:0]     addr_byte_we;

    // Software writes are locked out for the whole transfer.
    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (wr_addr == OFS_CMD) && (wr_data == CMD_PIO_RD);

    for (genvar b = 0; b < NAB; b++) begin : g_abyte
        assign addr_byte_we[b] = wr_ok && (wr_addr == addr_byte_ofs(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            opc_q   <= '0;
            rdata_q <= '0;
            fast_q  <= 1'b0;
            lane_q  <= '0;
        end else if (done) begin
            rdata_q <= rx_byte;
            addr_q  <= addr_q + FULL_AW'(1);
        end else if (wr_ok) begin
            if (wr_addr == OFS_OPC)  opc_q  <= wr_data;
            if (wr_addr == OFS_CFG)  fast_q <= wr_data[0];
            if (wr_addr == OFS_LANE) lane_q <= wr_data[3:0];
            for (int b = 0; b < NAB; b++) begin
                if (addr_byte_we[b]) addr_q[8*b +: 8] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == OFS_CMD)   rd_data = busy ? CMD_PIO_RD : 8'h00;
        if (rd_addr == OFS_RDATA) rd_data = rdata_q;
        if (rd_addr == OFS_OPC)   rd_data = opc_q;
        if (rd_addr == OFS_CFG)   rd_data = {7'b0, fast_q};
        if (rd_addr == OFS_LANE)  rd_data = {4'b0, lane_q};
        for (int b = 0; b < NAB; b++) begin
            if (rd_addr == addr_byte_ofs(b)) rd_data = addr_q[8*b +: 8];
        end
    end

    assign opcode     = opc_q;
    assign fast_en    = fast_q;
    assign lane_cfg   = lane_q;
    assign flash_addr = addr_q[ABITS-1:0];

endmodule

// File: rtl/nor_rd_lanes.sv
module nor_rd_lanes
    import nor_rd_pkg::*;
#(
    parameter int unsigned SHW = 24
) (
    input  phase_e            phase,
    input  lane_w_e           addr_w,
    input  logic [SHW-1:0]    sh,
    output logic [NUM_IO-1:0] io_out,
    output logic [NUM_IO-1:0] io_oe
);

    // Only the command and address phases drive the bus.
    always_comb begin
        io_out = '0;
        io_oe  = '0;
        case (phase)
            PH_OPC: begin
                io_out[0] = sh[SHW-1];
                io_oe[0]  = 1'b1;
            end
            PH_ADDR: begin
                case (addr_w)
                    LW_X4: begin
                        io_out[3:0] = sh[SHW-1 -: 4];
                        io_oe[3:0]  = 4'hF;
                    end
                    LW_X2: begin
                        io_out[1:0] = sh[SHW-1 -: 2];
                        io_oe[1:0]  = 2'b11;
                    end
                    default: begin
                        io_out[0] = sh[SHW-1];
                        io_oe[0]  = 1'b1;
                    end
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nor_rd_seq.sv
module nor_rd_seq
    import nor_rd_pkg::*;
#(
    parameter int unsigned ABITS = 24,
    parameter int unsigned DUMMY = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic              fast_en,
    input  logic [3:0]        lane_cfg,
    input  logic [ABITS-1:0]  flash_addr,
    input  logic [NUM_IO-1:0] io_in,
    output logic              sck,
    output logic              cs_n,
    output logic [NUM_IO-1:0] io_out,
    output logic [NUM_IO-1:0] io_oe,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rx_byte,
    output phase_e            phase
);

    localparam int unsigned SHW  = ABITS;
    localparam int unsigned CMAX = (ABITS > DUMMY) ? ABITS : DUMMY;
    localparam int unsigned CW   = $clog2(CMAX + 1);

    phase_e        phase_q;
    logic          sck_q;
    logic          cs_n_q;
    logic [CW-1:0] cnt_q;
    logic [SHW-1:0] sh_q;
    logic [7:0]    cap_q;
    xfer_mode_t    mode_q;

    function automatic logic [SHW-1:0] shift_out(input logic [SHW-1:0] v, input lane_w_e w);
        case (w)
            LW_X4:   return {v[SHW-5:0], 4'b0};
            LW_X2:   return {v[SHW-3:0], 2'b0};
            default: return {v[SHW-2:0], 1'b0};
        endcase
    endfunction

    // Single-lane data arrives on lane 1; wider modes use the low lanes.
    function automatic logic [7:0] shift_in(input logic [7:0] v, input logic [NUM_IO-1:0] d,
                                            input lane_w_e w);
        case (w)
            LW_X4:   return {v[3:0], d[3:0]};
            LW_X2:   return {v[5:0], d[1:0]};
            default: return {v[6:0], d[1]};
        endcase
    endfunction

    function automatic logic [CW-1:0] span(input int unsigned bits, input lane_w_e w);
        return CW'(bits / lane_bits(w) - 1);
    endfunction

    assign done = (phase_q == PH_DATA) && sck_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            cnt_q   <= '0;
            sh_q    <= '0;
            cap_q   <= '0;
            mode_q  <= '{addr_w: LW_X1, data_w: LW_X1, dummy: 1'b0};
        end else if (phase_q == PH_IDLE) begin
            if (start) begin
                phase_q <= PH_OPC;
                cs_n_q  <= 1'b0;
                sck_q   <= 1'b0;
                cnt_q   <= CW'(7);
                sh_q    <= {opcode, (SHW-8)'(0)};
                mode_q  <= mode_of(fast_en, lane_cfg);
            end
        end else if (!sck_q) begin
            // Rising serial edge: sample incoming data.
            sck_q <= 1'b1;
            if (phase_q == PH_DATA) cap_q <= shift_in(cap_q, io_in, mode_q.data_w);
        end else begin
            // Falling serial edge: advance outgoing bits or move to the next phase.
            sck_q <= 1'b0;
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
                sh_q  <= shift_out(sh_q, (phase_q == PH_OPC) ? LW_X1 : mode_q.addr_w);
            end else begin
                case (phase_q)
                    PH_OPC: begin
                        phase_q <= PH_ADDR;
                        sh_q    <= flash_addr;
                        cnt_q   <= span(ABITS, mode_q.addr_w);
                    end
                    PH_ADDR: begin
                        if (mode_q.dummy) begin
                            phase_q <= PH_DUMMY;
                            cnt_q   <= CW'(DUMMY - 1);
                        end else begin
                            phase_q <= PH_DATA;
                            cnt_q   <= span(8, mode_q.data_w);
                        end
                    end
                    PH_DUMMY: begin
                        phase_q <= PH_DATA;
                        cnt_q   <= span(8, mode_q.data_w);
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        cs_n_q  <= 1'b1;
                    end
                endcase
            end
        end
    end

    nor_rd_lanes #(.SHW(SHW)) u_lanes (
        .phase  (phase_q),
        .addr_w (mode_q.addr_w),
        .sh     (sh_q),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    assign sck     = sck_q;
    assign cs_n    = cs_n_q;
    assign busy    = (phase_q != PH_IDLE);
    assign rx_byte = cap_q;
    assign phase   = phase_q;

endmodule

// File: rtl/nor_pio_reader.sv
module nor_pio_reader
    import nor_rd_pkg::*;
#(
    parameter int unsigned FLASH_ABITS = 24,
    parameter int unsigned DUMMY_CLKS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic [NUM_IO-1:0] spi_io_out,
    output logic [NUM_IO-1:0] spi_io_oe,
    input  logic [NUM_IO-1:0] spi_io_in
);

    logic                   start_w;
    logic                   busy_w;
    logic                   done_w;
    logic [7:0]             rx_w;
    logic [7:0]             opcode_w;
    logic                   fast_w;
    logic [3:0]             lane_w;
    logic [FLASH_ABITS-1:0] flash_addr_w;
    phase_e                 phase_w;

    nor_rd_regs #(.ABITS(FLASH_ABITS), .NAB(NUM_ADDR_BYTES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy_w),
        .done       (done_w),
        .rx_byte    (rx_w),
        .start      (start_w),
        .opcode     (opcode_w),
        .fast_en    (fast_w),
        .lane_cfg   (lane_w),
        .flash_addr (flash_addr_w)
    );

    nor_rd_seq #(.ABITS(FLASH_ABITS), .DUMMY(DUMMY_CLKS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_w),
        .opcode     (opcode_w),
        .fast_en    (fast_w),
        .lane_cfg   (lane_w),
        .flash_addr (flash_addr_w),
        .io_in      (spi_io_in),
        .sck        (spi_sck),
        .cs_n       (spi_cs_n),
        .io_out     (spi_io_out),
        .io_oe      (spi_io_oe),
        .busy       (busy_w),
        .done       (done_w),
        .rx_byte    (rx_w),
        .phase      (phase_w)
    );

endmodule

// File: rtl/nor_pio_reader_chk.sv
module nor_pio_reader_chk
    import nor_rd_pkg::*;
#(
    parameter int unsigned ABITS = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             spi_sck,
    input logic             spi_cs_n,
    input logic [NUM_IO-1:0] spi_io_oe,
    input phase_e           phase,
    input logic             start,
    input logic             done,
    input logic             busy,
    input logic [ABITS-1:0] flash_addr,
    input logic [7:0]       opcode,
    input logic             wr_en
);

    AST_SCK_PARKED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);  // R9

    AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DUMMY || phase == PH_DATA) |-> (spi_io_oe == '0));  // R5

    AST_START_SELECT: assert property (@(posedge clk) disable iff (rst)
        start |=> (!spi_cs_n && busy));  // R2

    AST_DONE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        done |=> (spi_cs_n && !busy));  // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        done |=> (flash_addr == ABITS'($past(flash_addr) + 1)));  // R7

    AST_OPC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(opcode));  // R8

endmodule

bind nor_pio_reader nor_pio_reader_chk #(.ABITS(FLASH_ABITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_io_oe  (spi_io_oe),
    .phase      (phase_w),
    .start      (start_w),
    .done       (done_w),
    .busy       (busy_w),
    .flash_addr (flash_addr_w),
    .opcode     (opcode_w),
    .wr_en      (wr_en)
);

// File: tb/nor_pio_reader_tb.sv
`timescale 1ns/1ps
module nor_pio_reader_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_addr = 8'h0C;
    logic [7:0] rd_data;
    logic       spi_sck;
    logic       spi_cs_n;
    logic [3:0] spi_io_out;
    logic [3:0] spi_io_oe;
    logic [3:0] spi_io_in = 4'h0;

    always #4 clk = ~clk;

    nor_pio_reader u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .spi_sck    (spi_sck),
        .spi_cs_n   (spi_cs_n),
        .spi_io_out (spi_io_out),
        .spi_io_oe  (spi_io_oe),
        .spi_io_in  (spi_io_in)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  exp_q[$];
    int          m_aw = 1;
    int          m_dw = 1;
    int          m_dummy = 0;
    logic [7:0]  m_opc = 8'h03;
    string       m_tag = "R2";
    logic [31:0] cur_addr = 32'h0;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ (a[23:16] + 8'h5A);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int         fcnt = 0;
    logic [7:0] f_opc = 8'h00;
    logic [23:0] f_adr = 24'h0;
    logic [7:0] f_byte = 8'h00;

    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (!spi_sck) begin
            fcnt  = 0;
            f_opc = 8'h00;
            f_adr = 24'h0;
        end else begin
            if (fcnt < 8) f_opc = {f_opc[6:0], spi_io_out[0]};
            else if (fcnt < 8 + 24 / m_aw) begin
                if (m_aw == 4)      f_adr = {f_adr[19:0], spi_io_out[3:0]};
                else if (m_aw == 2) f_adr = {f_adr[21:0], spi_io_out[1:0]};
                else                f_adr = {f_adr[22:0], spi_io_out[0]};
            end
            fcnt++;
        end
    end

    always @(negedge spi_sck) begin
        int p;
        int k;
        p = 8 + 24 / m_aw + m_dummy;
        if (fcnt == p) f_byte = (f_opc == m_opc) ? memf(f_adr) : ~memf(f_adr);
        if (fcnt >= p && fcnt < p + 8 / m_dw) begin
            k = fcnt - p;
            if (m_dw == 4)      spi_io_in = f_byte[7-4*k -: 4];
            else if (m_dw == 2) spi_io_in = {2'b00, f_byte[7-2*k -: 2]};
            else                spi_io_in = {2'b00, f_byte[7-k], 1'b0};
        end
    end

    // ---------------- scoreboard monitor ----------------
    initial begin
        forever begin
            @(posedge spi_cs_n);
            if (exp_q.size() > 0) begin
                check({m_tag, " R9 serial clock count"}, fcnt, 8 + 24 / m_aw + m_dummy + 8 / m_dw);
                @(negedge clk);
                check({m_tag, " R6 read data"}, rd_data, exp_q.pop_front());
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wreg(input logic [7:0] ofs, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ofs; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chkreg(input string tag, input logic [7:0] ofs, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = ofs;
        #1;
        check(tag, rd_data, exp);
        rd_addr = 8'h0C;
    endtask

    task automatic set_addr(input logic [31:0] a);
        wreg(8'h10, a[7:0]);
        wreg(8'h14, a[15:8]);
        wreg(8'h18, a[23:16]);
        wreg(8'hC8, a[31:24]);
        cur_addr = a;
    endtask

    task automatic set_mode(input logic [7:0] opc, input logic [7:0] cfg, input logic [7:0] lane,
                            input int aw, input int dw, input int dummy, input string tag);
        wreg(8'h2C, opc);
        wreg(8'h60, cfg);
        wreg(8'hCC, lane);
        m_opc = opc; m_aw = aw; m_dw = dw; m_dummy = dummy; m_tag = tag;
    endtask

    task automatic do_reads(input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(memf(cur_addr[23:0]));
            wreg(8'h00, 8'h81);
            @(posedge spi_cs_n);
            @(negedge clk);
            @(negedge clk);
            cur_addr = cur_addr + 32'd1;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        int quiet;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 cs_n", spi_cs_n, 1'b1);
        check("R1 sck", spi_sck, 1'b0);
        check("R1 oe", spi_io_oe, 4'h0);
        chkreg("R1 cmd", 8'h00, 8'h00);
        chkreg("R1 rdata", 8'h0C, 8'h00);
        chkreg("R1 opcode", 8'h2C, 8'h00);
        chkreg("R1 lane", 8'hCC, 8'h00);
        chkreg("R1 addr top", 8'hC8, 8'h00);

        // R10: register widths and unmapped offsets
        wreg(8'h2C, 8'hA5);
        chkreg("R10 opcode", 8'h2C, 8'hA5);
        wreg(8'h60, 8'hFF);
        chkreg("R10 cfg", 8'h60, 8'h01);
        wreg(8'hCC, 8'hFF);
        chkreg("R10 lane", 8'hCC, 8'h0F);
        wreg(8'h44, 8'h77);
        chkreg("R10 unmapped", 8'h44, 8'h00);

        // R2 / R3: single-lane normal read, no dummy
        set_mode(8'h03, 8'h00, 8'h00, 1, 1, 0, "R2 R3 single");
        set_addr(32'h0000_0123);
        do_reads(3);

        // R4 + R7: fast read crossing a byte carry
        set_mode(8'h0B, 8'h01, 8'h00, 1, 1, 8, "R4 fast");
        set_addr(32'h0000_00FE);
        do_reads(3);
        chkreg("R7 carry low", 8'h10, 8'h01);
        chkreg("R7 carry mid", 8'h14, 8'h01);

        // R5: dual and quad data
        set_mode(8'h3B, 8'h00, 8'h01, 1, 2, 8, "R5 dual");
        set_addr(32'h0012_3456);
        do_reads(3);
        set_mode(8'h6B, 8'h00, 8'h04, 1, 4, 8, "R5 quad");
        set_addr(32'h00AB_CDEF);
        do_reads(3);
        set_mode(8'h6B, 8'h00, 8'h05, 1, 4, 8, "R5 quad priority");
        do_reads(2);

        // R3: wide address lanes
        set_mode(8'hBB, 8'h00, 8'h03, 2, 2, 8, "R3 dual address");
        set_addr(32'h0055_AA33);
        do_reads(2);
        set_mode(8'hEB, 8'h00, 8'h0C, 4, 4, 8, "R3 quad address");
        do_reads(2);
        set_mode(8'h03, 8'h00, 8'h08, 4, 1, 0, "R3 R4 quad address single data");
        do_reads(2);
        set_mode(8'h03, 8'h00, 8'h0A, 4, 1, 0, "R3 address priority");
        do_reads(1);

        // R7: full 32-bit wrap
        set_mode(8'h03, 8'h00, 8'h00, 1, 1, 0, "R7 wrap");
        set_addr(32'hFFFF_FFFF);
        do_reads(1);
        chkreg("R7 wrap b0", 8'h10, 8'h00);
        chkreg("R7 wrap b2", 8'h18, 8'h00);
        chkreg("R7 wrap b3", 8'hC8, 8'h00);

        // R8 + R2: writes during a transfer are discarded
        set_mode(8'h03, 8'h00, 8'h00, 1, 1, 0, "R8 busy");
        set_addr(32'h0000_0040);
        exp_q.push_back(memf(24'h000040));
        wreg(8'h00, 8'h81);
        repeat (3) @(negedge clk);
        chkreg("R2 busy flag", 8'h00, 8'h81);
        wreg(8'h2C, 8'hFF);
        wreg(8'h10, 8'h99);
        wreg(8'h00, 8'h81);
        @(posedge spi_cs_n);
        @(negedge clk);
        @(negedge clk);
        chkreg("R8 opcode kept", 8'h2C, 8'h03);
        chkreg("R8 address kept", 8'h10, 8'h41);
        chkreg("R2 flag cleared", 8'h00, 8'h00);
        quiet = 1;
        repeat (20) begin
            @(negedge clk);
            if (!spi_cs_n) quiet = 0;
        end
        check("R8 no second transfer", quiet, 1);

        // R2: other command values start nothing
        wreg(8'h00, 8'h04);
        quiet = 1;
        repeat (20) begin
            @(negedge clk);
            if (!spi_cs_n) quiet = 0;
        end
        check("R2 other command ignored", quiet, 1);
        check("R9 sck idle", spi_sck, 1'b0);
        check("R6 queue drained", exp_q.size(), 0);

        finish_run();
    end

endmodule